// File: doc/BRIEF.md
# Column-Parallel Majority Carry-Lookahead Adder Sequencer

This block models, at the behavioural level, a small resistive crossbar whose columns each act as a three-input majority gate. Word lines are rows shared by every column, and each column has one read latch that can drive its bit line with the stored bit or its complement. A sequencer uses the array to add two N-bit operands and a carry-in. Analog biasing, sneak paths and device variation are not modelled.

The addition runs in two phases. In the serial phase, for each bit position from the least significant upward, the sequencer takes two steps. It first fetches that position's incoming carry into the column latch, wherever the carry cell lives. It then evaluates a majority in that column, with the two operand rows on the word lines and the latch on the bit line. The result is written into the carry row. In the parallel phase, three steps produce every sum bit at once in all columns, so the phase length does not depend on N. The first step writes an intermediate row, MAJ(a, b, not c), using the inverted latch output. The second step writes a row with the complement of each carry-out. The third step writes the sum row, MAJ(intermediate, inverted carry-out, c), using the true latch output. In total an N-bit addition takes 2N+3 array steps.

Result cells can only be set and never cleared by an operation, so every scratch row is cleared when a new addition is accepted.

Top module: `majcla_top`

## Requirements
- R1: After synchronous reset, `done`, `carry_out`, `sum` and `step_count` are all 0.
- R2: When `done` is high, `{carry_out, sum}` equals `op_a + op_b + carry_in`, computed N+1 bits wide, using the operand values sampled on the clock edge that accepted `start`.
- R3: `done` rises exactly 2N+4 clock edges after the edge that accepted `start`, counting 2N serial steps, 3 parallel steps and one result-capture edge. While `done` is high, `step_count` equals 2N+3.
- R4: After the accept edge, `step_count` is 0. It then rises by exactly one on each step edge until it reaches 2N+3.
- R5: A `start` pulse during a running addition is ignored. It changes neither the result nor the latency.
- R6: Changes to `op_a`, `op_b` or `carry_in` after the accept edge do not affect the result.
- R7: Once high, `done` stays high with `sum` and `carry_out` unchanged until the next accepted `start`. The accept edge clears `done`.
- R8: Scratch rows are cleared on acceptance. An addition that follows one that set every scratch cell still gives its own correct result, for example 0+0+0 after all-ones + all-ones + 1.
- R9: A carry produced in bit 0 propagates through all N positions. For example, all-ones + 1 + 0 gives `sum` = 0 and `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an addition; accepted only when idle |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Incoming carry for bit 0 |
| sum | output | N | Registered sum bits |
| carry_out | output | 1 | Registered carry out of bit N-1 |
| done | output | 1 | Result valid; held until the next accepted start |
| step_count | output | $clog2(2N+4) | Array steps executed in the current or last addition |

## Verification
The hardest condition to reach from the ports is a scratch row holding leftover ones from a previous addition. Set-only cells would silently OR stale data into the next result. The stimulus therefore chains all-ones + all-ones + 1, which sets every carry, intermediate and sum cell, directly into 0+0+0 and checks the zero result. A second hard condition is a full-length carry ripple, where the serial fetch reaches every carry cell in turn. All-ones + 1 and alternating patterns with a carry-in force it. Start pulses and operand changes are also injected in the middle of a run to show that the captured operands and the step sequence are undisturbed.

// File: rtl/majcla_pkg.sv
package majcla_pkg;
  typedef enum logic [2:0] {
    ROW_OPA = 3'd0,
    ROW_OPB = 3'd1,
    ROW_CIN = 3'd2,
    ROW_CRY = 3'd3,
    ROW_MID = 3'd4,
    ROW_INV = 3'd5,
    ROW_SUM = 3'd6
  } row_e;

  localparam int ROWS = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_MAJ  = 2'd2,
    OP_NOT  = 2'd3
  } op_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction
endpackage

// File: rtl/majcla_xbar.sv
module majcla_xbar
  import majcla_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           op,
  input  row_e          wl_p,
  input  row_e          wl_q,
  input  row_e          dst,
  input  logic [N-1:0]  col_en,
  input  logic [N-1:0]  bl,
  input  logic [N-1:0]  ld_a,
  input  logic [N-1:0]  ld_b,
  input  logic          ld_c,
  input  row_e          rd_row,
  input  logic [IW-1:0] rd_col,
  output logic          rd_bit,
  output logic [N-1:0]  sum_row,
  output logic          cry_msb
);
  logic [N-1:0] cells [ROWS];
  logic [N-1:0] res;

  // One majority / inverter evaluation per column, all sharing the same word lines
  for (genvar c = 0; c < N; c++) begin : g_col
    always_comb begin
      if (op == OP_MAJ)
        res[c] = maj3(cells[int'(wl_p)][c], cells[int'(wl_q)][c], bl[c]);
      else
        res[c] = ~cells[int'(wl_p)][c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          // Operands written, every scratch row cleared
          for (int r = 0; r < ROWS; r++) cells[r] <= '0;
          cells[int'(ROW_OPA)] <= ld_a;
          cells[int'(ROW_OPB)] <= ld_b;
          cells[int'(ROW_CIN)] <= {{(N-1){1'b0}}, ld_c};
        end
        OP_MAJ, OP_NOT: begin
          // Result cells can only be set
          for (int c = 0; c < N; c++)
            if (col_en[c]) cells[int'(dst)][c] <= cells[int'(dst)][c] | res[c];
        end
        default: ;
      endcase
    end
  end

  assign rd_bit  = cells[int'(rd_row)][rd_col];
  assign sum_row = cells[int'(ROW_SUM)];
  assign cry_msb = cells[int'(ROW_CRY)][N-1];
endmodule

// File: rtl/majcla_latches.sv
module majcla_latches #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_en,
  input  logic [IW-1:0] fetch_col,
  input  logic          fetch_bit,
  input  logic          inv_sel,
  output logic [N-1:0]  bl
);
  logic [N-1:0] q;

  for (genvar c = 0; c < N; c++) begin : g_lat
    localparam logic [IW-1:0] CIDX = IW'(c);
    always_ff @(posedge clk) begin
      if (rst) q[c] <= 1'b0;
      else if (fetch_en && fetch_col == CIDX) q[c] <= fetch_bit;
    end
  end

  // Bit line driven from either the true or the complemented latch output
  assign bl = inv_sel ? ~q : q;
endmodule

// File: rtl/majcla_ctrl.sv
module majcla_ctrl
  import majcla_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int SW = $clog2(2*N+4),
  localparam int TOTAL = 2*N+3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output op_e           op,
  output row_e          wl_p,
  output row_e          wl_q,
  output row_e          dst,
  output logic [N-1:0]  col_en,
  output logic          fetch_en,
  output logic [IW-1:0] fetch_col,
  output row_e          rd_row,
  output logic [IW-1:0] rd_col,
  output logic          inv_sel,
  output logic          accept,
  output logic          busy,
  output logic          fin,
  output logic [SW-1:0] step_count
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_PMID, ST_PINV, ST_PSUM, ST_FIN
  } st_e;

  st_e           st;
  logic [IW-1:0] idx;
  localparam logic [IW-1:0] LAST = IW'(N-1);

  assign accept = (st == ST_IDLE) && start;
  assign busy   = (st == ST_FETCH) || (st == ST_EXEC) || (st == ST_PMID) ||
                  (st == ST_PINV)  || (st == ST_PSUM);
  assign fin    = (st == ST_FIN);

  always_comb begin
    op        = OP_NONE;
    wl_p      = ROW_OPA;
    wl_q      = ROW_OPB;
    dst       = ROW_CRY;
    col_en    = '0;
    fetch_en  = 1'b0;
    fetch_col = idx;
    rd_row    = ROW_CIN;
    rd_col    = '0;
    inv_sel   = 1'b0;
    case (st)
      ST_IDLE: if (start) op = OP_LOAD;
      ST_FETCH: begin
        // Incoming carry read from wherever it was stored
        fetch_en = 1'b1;
        if (idx != '0) begin
          rd_row = ROW_CRY;
          rd_col = idx - 1'b1;
        end
      end
      ST_EXEC: begin
        op     = OP_MAJ;
        col_en = N'(1) << idx;
        dst    = ROW_CRY;
      end
      ST_PMID: begin
        op      = OP_MAJ;
        col_en  = '1;
        inv_sel = 1'b1;
        dst     = ROW_MID;
      end
      ST_PINV: begin
        op     = OP_NOT;
        wl_p   = ROW_CRY;
        col_en = '1;
        dst    = ROW_INV;
      end
      ST_PSUM: begin
        op     = OP_MAJ;
        wl_p   = ROW_MID;
        wl_q   = ROW_INV;
        col_en = '1;
        dst    = ROW_SUM;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      idx        <= '0;
      step_count <= '0;
    end else begin
      if (busy) step_count <= step_count + 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          st         <= ST_FETCH;
          idx        <= '0;
          step_count <= '0;
        end
        ST_FETCH: st <= ST_EXEC;
        ST_EXEC: begin
          if (idx == LAST) st <= ST_PMID;
          else begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH;
          end
        end
        ST_PMID: st <= ST_PINV;
        ST_PINV: st <= ST_PSUM;
        ST_PSUM: st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/majcla_top.sv
module majcla_top
  import majcla_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int SW = $clog2(2*N+4)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  input  logic          carry_in,
  output logic [N-1:0]  sum,
  output logic          carry_out,
  output logic          done,
  output logic [SW-1:0] step_count
);
  op_e           op;
  row_e          wl_p, wl_q, dst, rd_row;
  logic [N-1:0]  col_en, bl, sum_row;
  logic          fetch_en, rd_bit, inv_sel, accept, busy, fin, cry_msb;
  logic [IW-1:0] fetch_col, rd_col;

  majcla_ctrl #(.N(N)) i_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .op(op), .wl_p(wl_p), .wl_q(wl_q), .dst(dst), .col_en(col_en),
    .fetch_en(fetch_en), .fetch_col(fetch_col), .rd_row(rd_row), .rd_col(rd_col),
    .inv_sel(inv_sel), .accept(accept), .busy(busy), .fin(fin),
    .step_count(step_count)
  );

  majcla_latches #(.N(N)) i_lat (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .fetch_col(fetch_col),
    .fetch_bit(rd_bit), .inv_sel(inv_sel), .bl(bl)
  );

  majcla_xbar #(.N(N)) i_xbar (
    .clk(clk), .rst(rst), .op(op), .wl_p(wl_p), .wl_q(wl_q), .dst(dst),
    .col_en(col_en), .bl(bl), .ld_a(op_a), .ld_b(op_b), .ld_c(carry_in),
    .rd_row(rd_row), .rd_col(rd_col), .rd_bit(rd_bit),
    .sum_row(sum_row), .cry_msb(cry_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      sum       <= '0;
      carry_out <= 1'b0;
    end else if (fin) begin
      done      <= 1'b1;
      sum       <= sum_row;
      carry_out <= cry_msb;
    end else if (accept) begin
      done      <= 1'b0;
    end
  end
endmodule

// File: rtl/majcla_chk.sv
module majcla_chk #(
  parameter int N = 8,
  localparam int SW = $clog2(2*N+4)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [N-1:0]  sum,
  input logic          carry_out,
  input logic [SW-1:0] step_count
);
  localparam logic [SW-1:0] TOTAL = SW'(2*N+3);

  AST_DONE_STEPS: assert property (@(posedge clk) disable iff (rst)
    done |-> step_count == TOTAL); // R3
  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R3
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    busy |=> step_count == $past(step_count) + 1'b1); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(sum) && $stable(carry_out))); // R7
endmodule

bind majcla_top majcla_chk #(.N(N)) i_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .sum(sum), .carry_out(carry_out), .step_count(step_count)
);

// File: tb/test_majcla_top.sv
module test_majcla_top;
  localparam int N  = 8;
  localparam int SW = $clog2(2*N+4);
  localparam int LAT = 2*N+4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  op_a = '0, op_b = '0;
  logic          carry_in = 1'b0;
  logic [N-1:0]  sum;
  logic          carry_out, done;
  logic [SW-1:0] step_count;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  majcla_top #(.N(N)) i_majcla_top (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sum(sum), .carry_out(carry_out), .done(done),
    .step_count(step_count)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One addition; poke_at>0 pulses start mid-run, scramble alters operands after accept
  task automatic run_add(input logic [N-1:0] a, input logic [N-1:0] b, input logic ci,
                         input int poke_at, input logic scramble,
                         output logic [N:0] res, output int lat, output logic steps_ok);
    int n;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    steps_ok = (step_count == '0) && !done;
    if (scramble) begin op_a = ~a; op_b = a ^ b; carry_in = ~ci; end
    while (!done && n < 4*LAT) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (step_count != SW'((n < 2*N+3) ? n : 2*N+3)) steps_ok = 1'b0;
      if (poke_at > 0 && n == poke_at) begin
        start = 1'b1; op_a = 8'h3c; op_b = 8'hc3; carry_in = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    res = {carry_out, sum};
    lat = n;
  endtask

  function automatic logic [N:0] ref_add(input logic [N-1:0] a, input logic [N-1:0] b, input logic ci);
    return {1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci};
  endfunction

  task automatic t_add(input logic [N-1:0] a, input logic [N-1:0] b, input logic ci, input string req);
    logic [N:0] r; int lat; logic ok;
    run_add(a, b, ci, 0, 1'b0, r, lat, ok);
    check(r == ref_add(a, b, ci), req, r, ref_add(a, b, ci));
    check(lat == LAT, "R3 latency", lat, LAT);
    check(step_count == SW'(2*N+3), "R3 step_count at done", step_count, 2*N+3);
    check(ok, "R4 step progression", ok, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(done == 1'b0, "R1 done", done, 0);
    check(sum == '0, "R1 sum", sum, 0);
    check(carry_out == 1'b0, "R1 carry_out", carry_out, 0);
    check(step_count == '0, "R1 step_count", step_count, 0);
  endtask

  task automatic t_busy_start;
    logic [N:0] r; int lat; logic ok;
    run_add(8'h5a, 8'h27, 1'b0, 3, 1'b0, r, lat, ok);
    check(r == ref_add(8'h5a, 8'h27, 1'b0), "R5 result after mid-run start", r, ref_add(8'h5a, 8'h27, 1'b0));
    check(lat == LAT, "R5 latency after mid-run start", lat, LAT);
  endtask

  task automatic t_scramble;
    logic [N:0] r; int lat; logic ok;
    run_add(8'h91, 8'h6e, 1'b1, 0, 1'b1, r, lat, ok);
    check(r == ref_add(8'h91, 8'h6e, 1'b1), "R6 operands changed after accept", r, ref_add(8'h91, 8'h6e, 1'b1));
  endtask

  task automatic t_hold;
    logic [N:0] r; int lat; logic ok; logic [N:0] held;
    run_add(8'hc8, 8'h4d, 1'b0, 0, 1'b0, r, lat, ok);
    held = r;
    op_a = 8'hff; op_b = 8'h01;
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R7 done held", done, 1);
    check({carry_out, sum} == held, "R7 result held", {carry_out, sum}, held);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7 done cleared on accept", done, 0);
    while (!done) @(negedge clk);
  endtask

  task automatic t_stale;
    t_add(8'hff, 8'hff, 1'b1, "R8 all-ones fill");
    t_add(8'h00, 8'h00, 1'b0, "R8 zero after full scratch");
  endtask

  task automatic t_ripple;
    t_add(8'hff, 8'h01, 1'b0, "R9 ripple all-ones plus one");
    t_add(8'h55, 8'haa, 1'b1, "R9 ripple through carry-in");
  endtask

  task automatic t_random;
    for (int k = 0; k < 24; k++) begin
      logic [N-1:0] a, b; logic ci;
      a = N'($urandom); b = N'($urandom); ci = 1'($urandom);
      t_add(a, b, ci, "R2 random sum");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_add(8'h00, 8'h00, 1'b0, "R2 zero");
    t_add(8'h12, 8'h34, 1'b0, "R2 small");
    t_ripple;
    t_stale;
    t_busy_start;
    t_scramble;
    t_hold;
    t_random;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule